// File: doc/BRIEF.md
# Software configuration-register unlock detector

This block sits on the memory side of a pseudo-static RAM port whose lower sixteen address bits share pins with the data bus. It watches each completed asynchronous cycle and looks for a fixed pattern of ordinary accesses that opens three internal 16-bit registers: refresh configuration, bus configuration and a read-only device identifier. The pattern is four cycles in a row, all to the top device address (22'h3FFFFF): a read, a second read, a write whose data picks the register, and a fourth cycle. If the fourth cycle is a write, its data loads the chosen register. If it is a read, the chosen register is driven onto the bus.

A dedicated configuration-enable strobe gives a second, hardware way to reach the same registers. The two paths work side by side, and holding the strobe low leaves the software pattern fully usable. The storage array is a small behavioural memory that block RAM can hold. Its low address bits index it, so the top device address maps onto its last word. The cycles that belong to the pattern never disturb that word.

Top module: `psram_cfg_unlock`

## Requirements
- R1: The detector recognises the cycle pattern read, read, write, write, with every cycle at address 22'h3FFFFF. When it sees this pattern, the data of the fourth cycle is loaded into the register chosen in the third cycle.
- R2: A cycle to any address other than 22'h3FFFFF returns the detector to idle. Such a cycle, including one that breaks a pending fourth step, is an ordinary array access, and no register changes.
- R3: The data of the third cycle chooses the register: 16'h0000 selects refresh configuration, 16'h0001 selects bus configuration, and 16'h0002 selects the device identifier.
- R4: When the fourth cycle is a read, all 16 bits of the chosen register are driven on adq_out with adq_oe high.
- R5: The array word at the top address keeps its value through every cycle that belongs to a recognised pattern, including the select write and the load write.
- R6: The device identifier cannot be written. A fourth-cycle write aimed at it leaves every register unchanged, and the detector is idle afterwards, so a new pattern can start on the next cycle.
- R7: A third-cycle data value other than 0000h, 0001h or 0002h cancels the pattern. That write, and the cycle that follows it, are ordinary array accesses.
- R8: A cycle that breaks the pattern is judged again as a possible first read. Four reads at the top address followed by a select write and a load write therefore still load the register.
- R9: While cre is high during address-valid, a write loads the register given by address bits [19:18] (0 refresh, 1 bus, 2 identifier, which is read-only) with address bits [15:0]. A read drives that register on the bus. Such cycles never touch the array. With cre held low, the software pattern still works.
- R10: After reset, refresh configuration reads 16'h0010, bus configuration reads 16'h9D1F and the identifier reads 16'h0C1B. adq_oe is low.
- R11: A cycle completes on the rising edge of cs_n. The address is taken from {addr_hi, adq_in} while adv_n is low. adq_oe is high only while cs_n and oe_n are low and we_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; its rising edge completes a cycle |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cre | input | 1 | Hardware configuration-register enable, sampled with the address |
| addr_hi | input | 6 | Upper address bits [21:16] |
| adq_in | input | 16 | Multiplexed address/data bus, inbound |
| adq_out | output | 16 | Read data driven to the bus |
| adq_oe | output | 1 | Drive enable for adq_out |

## Verification
The assertions assume that the strobes are synchronous to clk and that one cycle is in flight at a time. They also assume that adv_n is low only inside a chip-select window and that we_n rises before cs_n does. The bench drives every strobe on the falling clock edge. It keeps adv_n low for one clock at the start of each cycle and releases we_n one clock before cs_n. Reads are sampled several clocks after oe_n falls, once the two-register read path has settled.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RD1   = 2'd1,
    SQ_RD2   = 2'd2,
    SQ_ARMED = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_REFRESH = 2'd0,
    SEL_BUSCFG  = 2'd1,
    SEL_DEVID   = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_t;

  localparam int unsigned SEL_CODES = 3;

endpackage

// File: rtl/psram_bus_capture.sv
module psram_bus_capture #(
  parameter int unsigned AW = 22,
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             adv_n,
  input  logic             we_n,
  input  logic             cre,
  input  logic [AW-DW-1:0] addr_hi,
  input  logic [DW-1:0]    adq_in,
  output logic [AW-1:0]    addr_q,
  output logic             cre_q,
  output logic             wr_q,
  output logic [DW-1:0]    wdata_q,
  output logic             done
);

  logic cs_low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_low_q <= 1'b0;
      addr_q   <= '0;
      cre_q    <= 1'b0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      cs_low_q <= !cs_n;
      if (!cs_n && !adv_n) begin
        addr_q <= {addr_hi, adq_in};
        cre_q  <= cre;
        wr_q   <= 1'b0;
      end else if (!cs_n && !we_n) begin
        wr_q    <= 1'b1;
        wdata_q <= adq_in;
      end
    end
  end

  assign done = cs_low_q && cs_n;

  a_r11_done_after_select: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!cs_n));

endmodule

// File: rtl/psram_seq_detect.sv
module psram_seq_detect
  import psram_cfg_pkg::*;
#(
  parameter int unsigned AW = 22,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [AW-1:0] addr_q,
  input  logic          cre_q,
  input  logic          wr_q,
  input  logic [DW-1:0] wdata_q,
  output reg_sel_t      sel_q,
  output logic          hit,
  output logic          reg_we,
  output logic          arr_we
);

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  seq_state_t state_q, state_d;
  logic       at_top, rd_top, wr_top, code_ok, guard;

  assign at_top  = (addr_q == TOP_ADDR) && !cre_q;
  assign rd_top  = at_top && !wr_q;
  assign wr_top  = at_top && wr_q;
  assign code_ok = (wdata_q < DW'(SEL_CODES));

  always_comb begin
    state_d = state_q;
    if (done) begin
      unique case (state_q)
        SQ_IDLE:  state_d = rd_top ? SQ_RD1 : SQ_IDLE;
        SQ_RD1:   state_d = rd_top ? SQ_RD2 : SQ_IDLE;
        SQ_RD2: begin
          if (wr_top && code_ok) state_d = SQ_ARMED;
          else if (rd_top)       state_d = SQ_RD1;
          else                   state_d = SQ_IDLE;
        end
        default:  state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      sel_q   <= SEL_NONE;
    end else begin
      state_q <= state_d;
      if (done && state_q == SQ_RD2 && wr_top && code_ok)
        sel_q <= reg_sel_t'(wdata_q[1:0]);
      else if (done && state_q == SQ_ARMED)
        sel_q <= SEL_NONE;
    end
  end

  assign hit    = (state_q == SQ_ARMED) && at_top;
  assign guard  = at_top && ((state_q == SQ_RD2 && code_ok) || state_q == SQ_ARMED);
  assign reg_we = done && hit && wr_q;
  assign arr_we = done && wr_q && !cre_q && !guard;

  a_r2_abort_off_top: assert property (@(posedge clk) disable iff (rst)
    done && (addr_q != TOP_ADDR) |=> state_q == SQ_IDLE);

  a_r7_bad_code_cancels: assert property (@(posedge clk) disable iff (rst)
    done && state_q == SQ_RD2 && wr_q && !code_ok |=> state_q == SQ_IDLE);

  a_r8_restart_as_first: assert property (@(posedge clk) disable iff (rst)
    done && state_q == SQ_RD2 && rd_top |=> state_q == SQ_RD1);

  a_r3_armed_has_target: assert property (@(posedge clk) disable iff (rst)
    state_q == SQ_ARMED |-> sel_q != SEL_NONE);

  a_r5_top_word_guarded: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !arr_we);

endmodule

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
  import psram_cfg_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter logic [15:0] REF_INIT = 16'h0010,
  parameter logic [15:0] BUS_INIT = 16'h9D1F,
  parameter logic [15:0] DEV_ID   = 16'h0C1B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  reg_sel_t      sw_sel,
  input  logic [DW-1:0] sw_data,
  input  logic          hw_we,
  input  reg_sel_t      hw_sel,
  input  logic [DW-1:0] hw_data,
  input  reg_sel_t      rd_sel,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] ref_q, bus_q;
  logic          we;
  reg_sel_t      wsel;
  logic [DW-1:0] wdata;

  assign we    = sw_we || hw_we;
  assign wsel  = sw_we ? sw_sel : hw_sel;
  assign wdata = sw_we ? sw_data : hw_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= DW'(REF_INIT);
      bus_q <= DW'(BUS_INIT);
    end else if (we) begin
      if (wsel == SEL_REFRESH) ref_q <= wdata;
      if (wsel == SEL_BUSCFG)  bus_q <= wdata;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_REFRESH: rd_data = ref_q;
      SEL_BUSCFG:  rd_data = bus_q;
      SEL_DEVID:   rd_data = DW'(DEV_ID);
      default:     rd_data = '0;
    endcase
  end

  a_r1_soft_load: assert property (@(posedge clk) disable iff (rst)
    sw_we && sw_sel == SEL_REFRESH |=> ref_q == $past(sw_data));

  a_r6_devid_read_only: assert property (@(posedge clk) disable iff (rst)
    we && wsel == SEL_DEVID |=> $stable(ref_q) && $stable(bus_q));

  a_r9_strobe_load: assert property (@(posedge clk) disable iff (rst)
    hw_we && !sw_we && hw_sel == SEL_BUSCFG |=> bus_q == $past(hw_data));

endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int unsigned IW = 4,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/psram_cfg_unlock.sv
module psram_cfg_unlock
  import psram_cfg_pkg::*;
#(
  parameter int unsigned AW       = 22,
  parameter int unsigned DW       = 16,
  parameter int unsigned ARR_IW   = 4,
  parameter int unsigned HSEL_LSB = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             adv_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             cre,
  input  logic [AW-DW-1:0] addr_hi,
  input  logic [DW-1:0]    adq_in,
  output logic [DW-1:0]    adq_out,
  output logic             adq_oe
);

  logic [AW-1:0] addr_q;
  logic          cre_q, wr_q, done;
  logic [DW-1:0] wdata_q, mem_q, reg_q, src;
  reg_sel_t      sel_q, hw_sel, rd_sel;
  logic          hit, reg_we, arr_we, hw_we;

  psram_bus_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
    .cre(cre), .addr_hi(addr_hi), .adq_in(adq_in),
    .addr_q(addr_q), .cre_q(cre_q), .wr_q(wr_q), .wdata_q(wdata_q),
    .done(done)
  );

  psram_seq_detect #(.AW(AW), .DW(DW)) u_det (
    .clk(clk), .rst(rst), .done(done), .addr_q(addr_q), .cre_q(cre_q),
    .wr_q(wr_q), .wdata_q(wdata_q), .sel_q(sel_q), .hit(hit),
    .reg_we(reg_we), .arr_we(arr_we)
  );

  assign hw_sel = reg_sel_t'(addr_q[HSEL_LSB+1:HSEL_LSB]);
  assign hw_we  = done && cre_q && wr_q;
  assign rd_sel = cre_q ? hw_sel : sel_q;

  psram_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .sw_we(reg_we), .sw_sel(sel_q), .sw_data(wdata_q),
    .hw_we(hw_we), .hw_sel(hw_sel), .hw_data(addr_q[DW-1:0]),
    .rd_sel(rd_sel), .rd_data(reg_q)
  );

  psram_array #(.IW(ARR_IW), .DW(DW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(addr_q[ARR_IW-1:0]), .wdata(wdata_q),
    .raddr(addr_q[ARR_IW-1:0]), .rdata(mem_q)
  );

  assign src = (cre_q || hit) ? reg_q : mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      adq_out <= '0;
      adq_oe  <= 1'b0;
    end else begin
      adq_oe  <= !cs_n && !oe_n && we_n;
      adq_out <= src;
    end
  end

  a_r11_drive_needs_oe: assert property (@(posedge clk) disable iff (rst)
    adq_oe |-> $past(!oe_n) && $past(!cs_n));

  a_r9_strobe_spares_array: assert property (@(posedge clk) disable iff (rst)
    done && cre_q |-> !arr_we);

endmodule

// File: tb/psram_cfg_unlock_tb.sv
module psram_cfg_unlock_tb;

  localparam logic [21:0] TOP = 22'h3FFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, cre = 1'b0;
  logic [5:0]  addr_hi = '0;
  logic [15:0] adq_in = '0;
  logic [15:0] adq_out;
  logic        adq_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  event        smp_ev;

  always #2.5 clk = ~clk;

  psram_cfg_unlock u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .cre(cre), .addr_hi(addr_hi), .adq_in(adq_in),
    .adq_out(adq_out), .adq_oe(adq_oe)
  );

  // Monitor: pops one expected read per sample point.
  initial begin
    forever begin
      logic [15:0] e;
      string       t;
      @(smp_ev);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (adq_oe !== 1'b1 || adq_out !== e) begin
        errors++;
        $display("FAIL %s: got oe=%b data=%h expected oe=1 data=%h", t, adq_oe, adq_out, e);
      end
    end
  end

  task automatic bus_rd(input logic [21:0] a, input logic c, input logic [15:0] e,
                        input bit chk, input string t);
    @(negedge clk); cs_n = 0; adv_n = 0; cre = c; addr_hi = a[21:16]; adq_in = a[15:0];
    @(negedge clk); adv_n = 1; cre = 0; adq_in = '0; oe_n = 0;
    repeat (4) @(negedge clk);
    if (chk) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
      -> smp_ev;
    end
    #0.1 oe_n = 1;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [21:0] a, input logic c, input logic [15:0] d);
    @(negedge clk); cs_n = 0; adv_n = 0; cre = c; addr_hi = a[21:16]; adq_in = a[15:0];
    @(negedge clk); adv_n = 1; cre = 0; we_n = 0; adq_in = d;
    repeat (2) @(negedge clk);
    we_n = 1;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
  endtask

  task automatic seq_rd(input logic [15:0] sel, input logic [15:0] e, input string t);
    bus_rd(TOP, 0, '0, 0, "");
    bus_rd(TOP, 0, '0, 0, "");
    bus_wr(TOP, 0, sel);
    bus_rd(TOP, 0, e, 1, t);
  endtask

  task automatic seq_wr(input logic [15:0] sel, input logic [15:0] v);
    bus_rd(TOP, 0, '0, 0, "");
    bus_rd(TOP, 0, '0, 0, "");
    bus_wr(TOP, 0, sel);
    bus_wr(TOP, 0, v);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (adq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R10 idle drive: got %b expected 0", adq_oe);
    end

    // R10 / R3 / R4: reset values read back through the pattern
    seq_rd(16'h0000, 16'h0010, "R10 refresh default");
    seq_rd(16'h0001, 16'h9D1F, "R10 bus default");
    seq_rd(16'h0002, 16'h0C1B, "R10 R3 identifier");

    // R11: plain array accesses
    bus_wr(22'h000000, 0, 16'h1234);
    bus_wr(TOP, 0, 16'hA5A5);
    bus_rd(22'h000000, 0, 16'h1234, 1, "R11 array word 0");
    bus_rd(TOP, 0, 16'hA5A5, 1, "R11 array top word");
    bus_rd(22'h000000, 0, 16'h1234, 1, "R2 flush read");
    checks++;
    if (adq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R11 oe released: got %b expected 0", adq_oe);
    end

    // R1 / R5: software load of bus configuration
    seq_wr(16'h0001, 16'h1357);
    seq_rd(16'h0001, 16'h1357, "R1 bus load");
    bus_rd(TOP, 0, 16'hA5A5, 1, "R5 top word kept");
    bus_rd(22'h000000, 0, 16'h1234, 1, "R5 flush read");

    // R3 / R4: refresh register, full 16 bits
    seq_wr(16'h0000, 16'hBEEF);
    seq_rd(16'h0000, 16'hBEEF, "R3 R4 refresh load");
    seq_rd(16'h0001, 16'h1357, "R3 bus untouched");

    // R6: identifier is read-only, pattern ends cleanly
    seq_wr(16'h0002, 16'hFFFF);
    seq_rd(16'h0002, 16'h0C1B, "R6 identifier kept");
    seq_rd(16'h0000, 16'hBEEF, "R6 refresh kept");
    seq_rd(16'h0001, 16'h1357, "R6 bus kept");

    // R7: bad select code becomes ordinary writes
    bus_rd(TOP, 0, '0, 0, "");
    bus_rd(TOP, 0, '0, 0, "");
    bus_wr(TOP, 0, 16'h0005);
    bus_wr(TOP, 0, 16'h7777);
    bus_rd(TOP, 0, 16'h7777, 1, "R7 fourth cycle hit array");
    bus_rd(22'h000000, 0, 16'h1234, 1, "R7 flush read");
    seq_rd(16'h0001, 16'h1357, "R7 bus unchanged");

    // R8: extra reads restart as a first read
    repeat (4) bus_rd(TOP, 0, '0, 0, "");
    bus_wr(TOP, 0, 16'h0000);
    bus_wr(TOP, 0, 16'h2468);
    seq_rd(16'h0000, 16'h2468, "R8 load after restart");
    bus_rd(TOP, 0, 16'h7777, 1, "R8 R5 top word kept");
    bus_rd(22'h000000, 0, 16'h1234, 1, "R8 flush read");

    // R2: other address aborts before the select write
    bus_rd(TOP, 0, '0, 0, "");
    bus_rd(TOP, 0, '0, 0, "");
    bus_rd(22'h000000, 0, 16'h1234, 1, "R2 off-top read");
    bus_wr(TOP, 0, 16'h0001);
    bus_rd(TOP, 0, 16'h0001, 1, "R2 write became array write");
    bus_rd(22'h000000, 0, 16'h1234, 1, "R2 flush read");
    // R2: other address aborts the fourth step
    bus_rd(TOP, 0, '0, 0, "");
    bus_rd(TOP, 0, '0, 0, "");
    bus_wr(TOP, 0, 16'h0001);
    bus_wr(22'h000000, 0, 16'h4321);
    bus_rd(22'h000000, 0, 16'h4321, 1, "R2 broken fourth write to array");
    seq_rd(16'h0001, 16'h1357, "R2 bus unchanged");

    // R9: hardware strobe path
    bus_wr(22'h040ACE, 1, 16'h0000);
    bus_rd(22'h040000, 1, 16'h0ACE, 1, "R9 strobe read bus");
    seq_rd(16'h0001, 16'h0ACE, "R9 software sees strobe load");
    bus_wr(22'h001111, 1, 16'h0000);
    seq_rd(16'h0000, 16'h1111, "R9 strobe refresh load");
    bus_wr(22'h08BBBB, 1, 16'h0000);
    bus_rd(22'h080000, 1, 16'h0C1B, 1, "R9 strobe identifier read-only");
    bus_rd(TOP, 0, 16'h0001, 1, "R9 array top untouched");
    bus_rd(22'h000000, 0, 16'h4321, 1, "R9 array word 0 untouched");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule